// File: doc/BRIEF.md
# Multichannel Attenuation Latch Bank

This block keeps a digital volume setting for six output channels, arranged as three stereo pairs, and applies those settings to signed 24-bit audio samples. Each channel has two registers. The pending register takes new codes from a synchronous write port. The active register holds the setting that the sample path uses. A write carries a channel address, an 8-bit attenuation code and an update flag. When the update flag is set, every channel's pending code moves into its active register on the same clock edge, so that all channels change level together. A master address writes one code into every channel's pending register at once.

Code 0xFF is unity gain, and each step down from it attenuates by a further 0.5 dB. The sample path converts the code into a 12-entry mantissa and a right shift of one bit per 6 dB. It multiplies the sample by the mantissa, rounds, and shifts. Results appear two cycles after the sample is accepted, tagged with the same channel number. Code 0x00 silences the channel completely.

Top module: `atten_bank`

## Requirements
- R1: After reset every channel reads 0xFF in both its pending and its active register, and out_valid is low.
- R2: A write with wr_upd=0 to channel address n (0 to 5) loads wr_code into pending register n only; no active register changes.
- R3: A write with wr_upd=1 to a channel or master address stores the code and, on that same edge, copies every channel's pending code (including the one just written) into its active register.
- R4: A write to address 7 (master) loads wr_code into the pending register of all six channels; the wr_upd rule of R2/R3 applies unchanged.
- R5: A write to address 6 changes no pending and no active register, whatever the value of wr_upd.
- R6: The update flag is not stored: after a write, reading that channel's pending register returns exactly the 8-bit wr_code, whether wr_upd was 0 or 1.
- R7: For a nonzero code c, with a = 255 - c, sh = a / 12, k = a mod 12 and M_k = round(32768 * 10^(-k/40)), the output is floor((s * M_k + 2^(14+sh)) / 2^(15+sh)), where s is the signed sample.
- R8: A channel whose active code is 0x00 outputs exactly zero for every sample.
- R9: A sample accepted with in_valid high appears two cycles later with out_valid high and out_ch equal to its in_ch; in every other cycle out_valid is low.
- R10: A sample accepted in the same cycle as an update write is scaled with the active setting from before that write; the new setting applies from the next accepted sample onward.
- R11: Code 0xFF passes every sample through unchanged, full-scale positive and negative included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0-5 channel, 7 master, 6 unused |
| wr_code | input | 8 | Attenuation code, 0xFF unity, 0.5 dB per step |
| wr_upd | input | 1 | Update flag: move all pending codes to active |
| rd_addr | input | 3 | Channel selected for readback |
| rd_pend | output | 8 | Pending code of the selected channel (0 if out of range) |
| rd_act | output | 8 | Active code of the selected channel (0 if out of range) |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | 3 | Channel number of the sample |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Scaled sample present |
| out_ch | output | 3 | Channel number of the scaled sample |
| out_data | output | 24 | Signed scaled sample |

## Verification
The scaling is driven with random codes across the whole 0x00-0xFF range, with 0x00 and 0xFF favoured, and with random samples mixed with full-scale positive, full-scale negative, -1 and small values. This separates mantissa-table errors, shift-count errors, rounding and sign-extension mistakes, and the silence case. Random writes to channel, master and unused addresses, with the update flag both set and clear, show whether a pending code leaks into the active setting early, whether the update copies every channel, and whether the unused address has any effect. Directed cycles that place a sample on the update edge show whether the new setting is applied one sample too early.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
  localparam int CODE_W    = 8;
  localparam int MANT_FRAC = 15;
  localparam int MANT_W    = MANT_FRAC + 2;
  localparam int STEPS_PER_SHIFT = 12;
  localparam int SH_W      = 5;

  typedef struct packed {
    logic              mute;
    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] mant;
  } gain_t;

  // Mantissa for k half-dB steps below unity, Q1.15 format
  function automatic logic [MANT_W-1:0] step_mant(input logic [3:0] k);
    case (k)
      4'd0:    step_mant = 17'd32768;
      4'd1:    step_mant = 17'd30935;
      4'd2:    step_mant = 17'd29205;
      4'd3:    step_mant = 17'd27571;
      4'd4:    step_mant = 17'd26029;
      4'd5:    step_mant = 17'd24573;
      4'd6:    step_mant = 17'd23198;
      4'd7:    step_mant = 17'd21900;
      4'd8:    step_mant = 17'd20675;
      4'd9:    step_mant = 17'd19519;
      4'd10:   step_mant = 17'd18427;
      default: step_mant = 17'd17396;
    endcase
  endfunction

  // Split a code into mute flag, shift count and mantissa
  function automatic gain_t code_to_gain(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] att;
    logic [CODE_W-1:0] q;
    logic [CODE_W-1:0] r;
    att  = 8'hFF - code;
    q    = att / CODE_W'(STEPS_PER_SHIFT);
    r    = att % CODE_W'(STEPS_PER_SHIFT);
    code_to_gain.mute = (code == '0);
    code_to_gain.sh   = q[SH_W-1:0];
    code_to_gain.mant = step_mant(r[3:0]);
  endfunction
endpackage

// File: rtl/atten_regs.sv
`timescale 1ns/1ps
module atten_regs #(
  parameter int NCH         = 6,
  parameter int AW          = 3,
  parameter int MASTER_ADDR = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [atten_pkg::CODE_W-1:0]      wr_code,
  input  logic                              wr_upd,
  output logic [NCH*atten_pkg::CODE_W-1:0]  pend_flat,
  output logic [NCH*atten_pkg::CODE_W-1:0]  act_flat,
  output logic                              upd_evt
);
  import atten_pkg::*;

  logic addr_is_master;
  logic addr_is_chan;

  assign addr_is_master = (int'(wr_addr) == MASTER_ADDR);
  assign addr_is_chan   = (int'(wr_addr) < NCH);
  assign upd_evt        = wr_en && wr_upd && (addr_is_chan || addr_is_master);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] pend_q, pend_d, act_q;

    assign hit    = wr_en && ((int'(wr_addr) == c) || addr_is_master);
    assign pend_d = hit ? wr_code : pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 8'hFF;
        act_q  <= 8'hFF;
      end else begin
        pend_q <= pend_d;
        if (upd_evt) act_q <= pend_d;
      end
    end

    assign pend_flat[c*CODE_W +: CODE_W] = pend_q;
    assign act_flat[c*CODE_W +: CODE_W]  = act_q;
  end
endmodule

// File: rtl/atten_scale.sv
`timescale 1ns/1ps
module atten_scale #(
  parameter int NCH = 6,
  parameter int AW  = 3,
  parameter int DW  = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCH*atten_pkg::CODE_W-1:0]  act_flat,
  input  logic                              in_valid,
  input  logic [AW-1:0]                     in_ch,
  input  logic [DW-1:0]                     in_data,
  output logic                              s1_vld,
  output logic                              s1_zero,
  output logic                              out_valid,
  output logic [AW-1:0]                     out_ch,
  output logic [DW-1:0]                     out_data
);
  import atten_pkg::*;

  localparam int PW = DW + MANT_W;

  logic [CODE_W-1:0] sel_code;
  gain_t             sel_gain;

  always_comb begin
    sel_code = 8'hFF;
    for (int c = 0; c < NCH; c++)
      if (int'(in_ch) == c) sel_code = act_flat[c*CODE_W +: CODE_W];
  end
  assign sel_gain = code_to_gain(sel_code);

  // Stage 1: capture sample with the gain in force at acceptance
  gain_t          s1_gain;
  logic [DW-1:0]  s1_data;
  logic [AW-1:0]  s1_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_gain <= '0;
      s1_data <= '0;
      s1_ch   <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_gain <= sel_gain;
        s1_data <= in_data;
        s1_ch   <= in_ch;
      end
    end
  end
  assign s1_zero = s1_gain.mute;

  // Stage 2: multiply, round, shift
  logic signed [PW-1:0] prod, rnd, res;
  always_comb begin
    prod = PW'($signed(s1_data)) * $signed({1'b0, s1_gain.mant});
    rnd  = PW'(1) << (MANT_FRAC - 1 + int'(s1_gain.sh));
    res  = (prod + rnd) >>> (MANT_FRAC + int'(s1_gain.sh));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_ch   <= s1_ch;
        out_data <= s1_gain.mute ? '0 : res[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/atten_bank.sv
`timescale 1ns/1ps
module atten_bank #(
  parameter int NCH         = 6,
  parameter int AW          = 3,
  parameter int DW          = 24,
  parameter int MASTER_ADDR = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_code,
  input  logic          wr_upd,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_pend,
  output logic [7:0]    rd_act,
  input  logic          in_valid,
  input  logic [AW-1:0] in_ch,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_ch,
  output logic [DW-1:0] out_data
);
  import atten_pkg::*;

  logic [NCH*CODE_W-1:0] pend_flat;
  logic [NCH*CODE_W-1:0] act_flat;
  logic                  upd_evt;
  logic                  s1_vld;
  logic                  s1_zero;

  atten_regs #(.NCH(NCH), .AW(AW), .MASTER_ADDR(MASTER_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_code(wr_code), .wr_upd(wr_upd),
    .pend_flat(pend_flat), .act_flat(act_flat), .upd_evt(upd_evt)
  );

  atten_scale #(.NCH(NCH), .AW(AW), .DW(DW)) u_scale (
    .clk(clk), .rst_n(rst_n), .act_flat(act_flat),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .s1_vld(s1_vld), .s1_zero(s1_zero),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  always_comb begin
    rd_pend = '0;
    rd_act  = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(rd_addr) == c) begin
        rd_pend = pend_flat[c*CODE_W +: CODE_W];
        rd_act  = act_flat[c*CODE_W +: CODE_W];
      end
  end
endmodule

// File: rtl/atten_bank_chk.sv
`timescale 1ns/1ps
module atten_bank_chk #(
  parameter int NCH         = 6,
  parameter int AW          = 3,
  parameter int DW          = 24,
  parameter int MASTER_ADDR = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [7:0]        wr_code,
  input logic              wr_upd,
  input logic [NCH*8-1:0]  pend_flat,
  input logic [NCH*8-1:0]  act_flat,
  input logic              upd_evt,
  input logic              in_valid,
  input logic              s1_vld,
  input logic              s1_zero,
  input logic              out_valid,
  input logic [DW-1:0]     out_data
);
  logic unused_addr;
  assign unused_addr = (int'(wr_addr) >= NCH) && (int'(wr_addr) != MASTER_ADDR);

  a_r2_no_early_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_upd) |=> $stable(act_flat));

  a_r3_all_copied: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_upd && !unused_addr) |=> (act_flat == pend_flat));

  a_r3_event_matches: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> (wr_en && wr_upd));

  for (genvar c = 0; c < NCH; c++) begin : g_m
    a_r4_master_fanout: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == MASTER_ADDR) |=> (pend_flat[c*8 +: 8] == $past(wr_code)));
  end

  a_r5_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unused_addr) |=> ($stable(pend_flat) && $stable(act_flat)));

  a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_zero) |=> (out_data == '0));

  a_r9_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld);

  a_r9_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid);
endmodule

bind atten_bank atten_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW), .MASTER_ADDR(MASTER_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
  .wr_upd(wr_upd), .pend_flat(pend_flat), .act_flat(act_flat), .upd_evt(upd_evt),
  .in_valid(in_valid), .s1_vld(s1_vld), .s1_zero(s1_zero),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_atten_bank.sv
`timescale 1ns/1ps
module sim_atten_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_code = '0;
  logic        wr_upd = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_pend, rd_act;
  logic        in_valid = 1'b0;
  logic [2:0]  in_ch = '0;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic [2:0]  out_ch;
  logic [23:0] out_data;

  atten_bank u0 (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pm [6];
  logic [7:0] am [6];
  logic        e1v = 0, e2v = 0;
  logic [2:0]  e1c = 0, e2c = 0;
  logic [23:0] e1d = 0, e2d = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Gain restated from R7 with real arithmetic for the mantissa
  function automatic logic [23:0] ref_gain(input logic [7:0] code, input logic [23:0] s);
    int a, sh, k, m;
    longint p;
    if (code == 8'h00) return 24'h0;
    a  = 255 - int'(code);
    sh = a / 12;
    k  = a % 12;
    m  = $rtoi(32768.0 * (10.0 ** (-real'(k) / 40.0)) + 0.5);
    p  = longint'($signed(s)) * longint'(m);
    p  = p + (longint'(1) <<< (14 + sh));
    p  = p >>> (15 + sh);
    return p[23:0];
  endfunction

  task automatic tick();
    @(posedge clk);
    e2v = e1v; e2c = e1c; e2d = e1d;
    e1v = in_valid;
    if (in_valid) begin
      e1c = in_ch;
      e1d = (in_ch < 6) ? ref_gain(am[in_ch], in_data) : in_data;
    end
    if (wr_en) begin
      if (wr_addr < 6) pm[wr_addr] = wr_code;
      else if (wr_addr == 7) for (int c = 0; c < 6; c++) pm[c] = wr_code;
      if (wr_upd && wr_addr != 6) for (int c = 0; c < 6; c++) am[c] = pm[c];
    end
    @(negedge clk);
    chk(out_valid == e2v, "R9 out_valid", out_valid, e2v);
    if (e2v) begin
      chk(out_ch == e2c, "R9 out_ch", out_ch, e2c);
      chk(out_data == e2d, "R7 out_data", out_data, e2d);
    end
    if (rd_addr < 6) begin
      chk(rd_pend == pm[rd_addr], "R2 rd_pend", rd_pend, pm[rd_addr]);
      chk(rd_act == am[rd_addr], "R3 rd_act", rd_act, am[rd_addr]);
    end
    wr_en = 0; in_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] c, input logic u);
    wr_en = 1; wr_addr = a; wr_code = c; wr_upd = u;
  endtask

  task automatic smp(input logic [2:0] ch, input logic [23:0] d);
    in_valid = 1; in_ch = ch; in_data = d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 6; c++) begin pm[c] = 8'hFF; am[c] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    for (int c = 0; c < 6; c++) begin
      rd_addr = 3'(c); #1;
      chk(rd_pend == 8'hFF && rd_act == 8'hFF, "R1 reset codes", {rd_pend, rd_act}, 16'hFFFF);
    end
    // R11: unity at full scale
    smp(0, 24'h7FFFFF); tick();
    smp(1, 24'h800000); tick();
    chk(out_data == 24'h7FFFFF, "R11 +full", out_data, 24'h7FFFFF);
    tick();
    chk(out_data == 24'h800000, "R11 -full", out_data, 24'h800000);
    // R2: pending only
    rd_addr = 2; wr(2, 8'h80, 0); tick();
    chk(rd_act == 8'hFF && rd_pend == 8'h80, "R2 pending only", {rd_pend, rd_act}, 16'h80FF);
    // R10: sample on update edge uses old setting
    rd_addr = 2; wr(2, 8'h80, 1); smp(2, 24'h100000); tick();
    chk(rd_act == 8'h80, "R3 applied", rd_act, 8'h80);
    tick();
    chk(out_data == 24'h100000, "R10 old gain on update edge", out_data, 24'h100000);
    smp(2, 24'h100000); tick(); tick();
    chk(out_data == ref_gain(8'h80, 24'h100000), "R10 new gain next sample", out_data, ref_gain(8'h80, 24'h100000));
    // R6: update flag not stored in readback
    rd_addr = 4; wr(4, 8'h5A, 1); tick();
    chk(rd_pend == 8'h5A, "R6 readback code", rd_pend, 8'h5A);
    // R5: unused address ignored
    rd_addr = 1; wr(1, 8'h33, 0); tick();
    wr(6, 8'h00, 1); tick();
    chk(rd_pend == 8'h33 && rd_act == 8'hFF, "R5 unused addr", {rd_pend, rd_act}, 16'h33FF);
    // R4: master fan-out then update
    wr(7, 8'h00, 0); tick();
    for (int c = 0; c < 6; c++) begin
      rd_addr = 3'(c); #1;
      chk(rd_pend == 8'h00, "R4 master pending", rd_pend, 8'h00);
    end
    wr(7, 8'h00, 1); tick();
    // R8: mute
    smp(3, 24'h7FFFFF); tick(); tick();
    chk(out_data == 24'h0, "R8 mute", out_data, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      rd_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 3) begin
        r = $urandom_range(0, 9);
        wr(3'($urandom_range(0, 7)),
           (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom_range(0, 255)),
           1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 9) < 7) begin
        r = $urandom_range(0, 9);
        smp(3'($urandom_range(0, 5)),
            (r == 0) ? 24'h7FFFFF : (r == 1) ? 24'h800000 : (r == 2) ? 24'hFFFFFF :
            (r == 3) ? 24'($urandom_range(0, 63)) : 24'($urandom));
      end
      tick();
    end
    tick(); tick();
    finish_run();
  end
endmodule